// File: doc/BRIEF.md
# Internal Data Memory Mapper for an 8-bit Microcontroller Core

This block takes each data-memory access that the core issues and works out which piece of storage it reaches. There are three on-chip stores: a 256-byte internal scratch RAM, the special function register space, and a 768-byte expansion RAM. The same byte address can reach different storage depending on the access type. A direct access above 7Fh reaches a special function register, while an indirect access to the same address reaches upper scratch RAM. Register operands are relocated by the two bank-select bits. Bit operands are folded onto a byte and a bit position. External-bus moves reach the expansion RAM only when its enable bit is set.

The block holds the stack pointer, the 16-bit data pointer, the accumulator, the status word and the system-control register. The parity flag in the status word is derived from the accumulator and is never stored. A push increments the stack pointer and then writes. A pop reads and then decrements. Read data comes back combinationally in the same cycle as the request, and writes take effect on the next rising clock edge. A bit write is carried out as a read-modify-write of the containing byte within one cycle.

Top module: `dmem_map`

## Requirements
- R1: A direct access (kind 0) to 00h–7Fh reaches internal RAM. A direct access to 80h–FFh reaches the SFR space. Reads of unimplemented SFRs return 00h, and writes to them are dropped.
- R2: An indirect access (kind 1) to any address 00h–FFh reaches internal RAM, so indirect and direct accesses to the same address above 7Fh reach different storage.
- R3: A register access (kind 3) with operand n = addr[2:0] reaches internal RAM byte {3'b000, RS, n}, where RS is status-word bits 4:3.
- R4: A bit access (kind 2) with bit address below 80h reaches RAM byte 20h + addr[6:3], bit addr[2:0]. A bit read returns that bit in rd_data[0]. A bit write sets that bit to wdata[0] and leaves the other seven bits unchanged.
- R5: A bit access with bit address 80h or above reaches SFR byte {addr[7:3],3'b000}, bit addr[2:0].
- R6: The status word sits at SFR D0h with the layout carry(7), aux carry(6), user flag(5), RS1(4), RS0(3), overflow(2), spare(1), parity(0). Parity always equals the XOR of the accumulator at SFR E0h, and writes to bit 0 are ignored.
- R7: The stack pointer sits at SFR 81h and resets to 07h. A push (kind 5) first increments it and then writes wdata to internal RAM at the new value. A pop (kind 6) returns the byte at the current value and then decrements it. The pointer wraps modulo 256, and stack accesses above 7Fh use indirect mapping.
- R8: The data pointer's low byte is at SFR 82h and its high byte at SFR 83h. Both reset to 00h and appear together on dptr_q.
- R9: The system-control register at SFR BFh resets to 00h. Its bit 0 is the expansion enable. While the enable is set, an external move (kind 4) to 0000h–02FFh reaches the 768-byte expansion RAM.
- R10: An external move is flagged off_chip when the enable is clear or the address is above 02FFh. Such a move leaves the expansion RAM unchanged and reads 00h.
- R11: After reset, sp_q = 07h, dptr_q = 0000h and psw_q = 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request this cycle |
| req_kind | input | 3 | 0 direct, 1 indirect, 2 bit, 3 register, 4 external move, 5 push, 6 pop |
| req_addr | input | 16 | Byte, bit or register address; all 16 bits used by external moves |
| req_we | input | 1 | Write request (push always writes, pop never writes) |
| req_wdata | input | 8 | Write byte; bit 0 is the value for bit writes |
| rd_data | output | 8 | Read byte, or the bit in position 0 for bit reads |
| rd_bit | output | 1 | Addressed bit of the selected byte |
| off_chip | output | 1 | External move not served on chip |
| sp_q | output | 8 | Stack pointer |
| dptr_q | output | 16 | Data pointer {high, low} |
| psw_q | output | 8 | Status word including derived parity |

## Verification
The bench targets the split at 80h. A write through one access type followed by a read through the other shows that direct and indirect accesses are kept apart. A design that ignored the access type would make the SFR and upper RAM alias one another. All four bank settings are swept with all eight registers and read back indirectly, which exposes a swapped or ignored bank bit. Bit writes into the bit area and onto the accumulator check the byte folding and the preservation of neighbouring bits, and a bit write of 0 to the status word checks that parity cannot be overwritten. The stack tests cover pre-increment versus post-decrement order and wrap-around at FFh. The expansion-enable tests show that a disabled or out-of-range external move neither writes the array nor aliases onto low addresses.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    typedef enum logic [2:0] {
        K_DIRECT   = 3'd0,
        K_INDIRECT = 3'd1,
        K_BIT      = 3'd2,
        K_REG      = 3'd3,
        K_MOVX     = 3'd4,
        K_PUSH     = 3'd5,
        K_POP      = 3'd6,
        K_IDLE     = 3'd7
    } kind_e;

    typedef enum logic [2:0] {
        T_NONE = 3'd0,
        T_IRAM = 3'd1,
        T_SFR  = 3'd2,
        T_XRAM = 3'd3,
        T_OFF  = 3'd4
    } tgt_e;

    typedef struct packed {
        tgt_e        tgt;
        logic [15:0] off;
        logic        is_bit;
        logic [2:0]  bpos;
    } route_t;

    localparam logic [7:0] SFR_SP     = 8'h81;
    localparam logic [7:0] SFR_DPL    = 8'h82;
    localparam logic [7:0] SFR_DPH    = 8'h83;
    localparam logic [7:0] SFR_SYSCTL = 8'hBF;
    localparam logic [7:0] SFR_PSW    = 8'hD0;
    localparam logic [7:0] SFR_ACC    = 8'hE0;

    localparam logic [7:0] SP_RESET   = 8'h07;
    localparam logic [7:0] BIT_AREA   = 8'h20;
    localparam int unsigned XEN_POS   = 0;

    function automatic logic [7:0] bit_home(input logic [7:0] ba);
        if (ba[7]) return {ba[7:3], 3'b000};
        return BIT_AREA + {4'b0000, ba[6:3]};
    endfunction

    function automatic logic [7:0] bit_merge(input logic [7:0] b,
                                             input logic [2:0] pos,
                                             input logic       v);
        logic [7:0] r;
        r      = b;
        r[pos] = v;
        return r;
    endfunction

endpackage

// File: rtl/dmem_ram.sv
module dmem_ram #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/dmem_decode.sv
module dmem_decode
    import dmem_pkg::*;
#(
    parameter int unsigned XRAM_BYTES = 768
) (
    input  kind_e       kind,
    input  logic [15:0] addr,
    input  logic [1:0]  rs,
    input  logic [7:0]  sp,
    input  logic        xen,
    output route_t      rt
);
    localparam logic [16:0] XLIM = 17'(XRAM_BYTES);

    always_comb begin
        rt        = '0;
        rt.tgt    = T_NONE;
        rt.bpos   = addr[2:0];
        unique case (kind)
            K_DIRECT: begin
                rt.tgt = addr[7] ? T_SFR : T_IRAM;
                rt.off = {8'h00, addr[7:0]};
            end
            K_INDIRECT: begin
                rt.tgt = T_IRAM;
                rt.off = {8'h00, addr[7:0]};
            end
            K_BIT: begin
                rt.tgt    = addr[7] ? T_SFR : T_IRAM;
                rt.off    = {8'h00, bit_home(addr[7:0])};
                rt.is_bit = 1'b1;
            end
            K_REG: begin
                rt.tgt = T_IRAM;
                rt.off = {11'd0, rs, addr[2:0]};
            end
            K_MOVX: begin
                if (xen && ({1'b0, addr} < XLIM)) rt.tgt = T_XRAM;
                else                               rt.tgt = T_OFF;
                rt.off = addr;
            end
            K_PUSH: begin
                rt.tgt = T_IRAM;
                rt.off = {8'h00, sp + 8'd1};
            end
            K_POP: begin
                rt.tgt = T_IRAM;
                rt.off = {8'h00, sp};
            end
            default: rt.tgt = T_NONE;
        endcase
    end
endmodule

// File: rtl/dmem_sfr.sv
module dmem_sfr
    import dmem_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [7:0]  addr,
    input  logic [7:0]  wdata,
    input  logic        push,
    input  logic        pop,
    output logic [7:0]  rdata,
    output logic [7:0]  sp,
    output logic [15:0] dptr,
    output logic [7:0]  psw,
    output logic        xen
);
    logic [7:0] acc_r, dpl_r, dph_r, sys_r, sp_r;
    logic [6:0] psw_hi;

    assign psw  = {psw_hi, ^acc_r};
    assign sp   = sp_r;
    assign dptr = {dph_r, dpl_r};
    assign xen  = sys_r[XEN_POS];

    always_comb begin
        unique case (addr)
            SFR_SP:     rdata = sp_r;
            SFR_DPL:    rdata = dpl_r;
            SFR_DPH:    rdata = dph_r;
            SFR_SYSCTL: rdata = sys_r;
            SFR_PSW:    rdata = psw;
            SFR_ACC:    rdata = acc_r;
            default:    rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_r  <= 8'h00;
            dpl_r  <= 8'h00;
            dph_r  <= 8'h00;
            sys_r  <= 8'h00;
            psw_hi <= 7'd0;
            sp_r   <= SP_RESET;
        end else begin
            if (push)                        sp_r <= sp_r + 8'd1;
            else if (pop)                    sp_r <= sp_r - 8'd1;
            else if (wr && addr == SFR_SP)   sp_r <= wdata;
            if (wr) begin
                unique case (addr)
                    SFR_DPL:    dpl_r  <= wdata;
                    SFR_DPH:    dph_r  <= wdata;
                    SFR_SYSCTL: sys_r  <= wdata;
                    SFR_PSW:    psw_hi <= wdata[7:1];
                    SFR_ACC:    acc_r  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assert_parity_tracks_acc_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == SFR_ACC) |=> (psw[0] == ^$past(wdata)));

    assert_parity_not_writable_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == SFR_PSW) |=> (psw[0] == $past(psw[0])));

    assert_push_preinc_R7: assert property (@(posedge clk) disable iff (rst)
        push |=> (sp == $past(sp) + 8'd1));

    assert_pop_postdec_R7: assert property (@(posedge clk) disable iff (rst)
        pop |=> (sp == $past(sp) - 8'd1));

    assert_xen_follows_write_R9: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == SFR_SYSCTL) |=> (xen == $past(wdata[XEN_POS])));
endmodule

// File: rtl/dmem_map.sv
module dmem_map
    import dmem_pkg::*;
#(
    parameter int unsigned IRAM_BYTES = 256,
    parameter int unsigned XRAM_BYTES = 768
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [2:0]  req_kind,
    input  logic [15:0] req_addr,
    input  logic        req_we,
    input  logic [7:0]  req_wdata,
    output logic [7:0]  rd_data,
    output logic        rd_bit,
    output logic        off_chip,
    output logic [7:0]  sp_q,
    output logic [15:0] dptr_q,
    output logic [7:0]  psw_q
);
    localparam int unsigned IAW = $clog2(IRAM_BYTES);
    localparam int unsigned XAW = $clog2(XRAM_BYTES);

    kind_e      kind;
    route_t     rt;
    logic       xen, do_wr, push, pop;
    logic       iram_we, sfr_wr, xram_we;
    logic [7:0] iram_rd, sfr_rd, xram_rd, rbyte, wbyte;

    assign kind = req_valid ? kind_e'(req_kind) : K_IDLE;
    assign push = (kind == K_PUSH);
    assign pop  = (kind == K_POP);

    dmem_decode #(.XRAM_BYTES(XRAM_BYTES)) u_dec (
        .kind (kind),
        .addr (req_addr),
        .rs   (psw_q[4:3]),
        .sp   (sp_q),
        .xen  (xen),
        .rt   (rt)
    );

    always_comb begin
        unique case (rt.tgt)
            T_IRAM:  rbyte = iram_rd;
            T_SFR:   rbyte = sfr_rd;
            T_XRAM:  rbyte = xram_rd;
            default: rbyte = 8'h00;
        endcase
    end

    assign wbyte   = rt.is_bit ? bit_merge(rbyte, rt.bpos, req_wdata[0]) : req_wdata;
    assign do_wr   = (req_we && !pop && kind != K_IDLE) || push;
    assign iram_we = do_wr && rt.tgt == T_IRAM;
    assign sfr_wr  = do_wr && rt.tgt == T_SFR;
    assign xram_we = do_wr && rt.tgt == T_XRAM;

    dmem_ram #(.DEPTH(IRAM_BYTES)) u_iram (
        .clk   (clk),
        .we    (iram_we),
        .addr  (rt.off[IAW-1:0]),
        .wdata (wbyte),
        .rdata (iram_rd)
    );

    dmem_ram #(.DEPTH(XRAM_BYTES)) u_xram (
        .clk   (clk),
        .we    (xram_we),
        .addr  (rt.off[XAW-1:0]),
        .wdata (wbyte),
        .rdata (xram_rd)
    );

    dmem_sfr u_sfr (
        .clk   (clk),
        .rst   (rst),
        .wr    (sfr_wr),
        .addr  (rt.off[7:0]),
        .wdata (wbyte),
        .push  (push),
        .pop   (pop),
        .rdata (sfr_rd),
        .sp    (sp_q),
        .dptr  (dptr_q),
        .psw   (psw_q),
        .xen   (xen)
    );

    assign rd_bit   = rbyte[rt.bpos];
    assign rd_data  = rt.is_bit ? {7'd0, rd_bit} : rbyte;
    assign off_chip = (rt.tgt == T_OFF);

    assert_movx_disabled_off_R10: assert property (@(posedge clk) disable iff (rst)
        (kind == K_MOVX && !xen) |-> (off_chip && !xram_we));

    assert_indirect_never_sfr_R2: assert property (@(posedge clk) disable iff (rst)
        (kind == K_INDIRECT) |-> !sfr_wr);

    assert_reg_bank_R3: assert property (@(posedge clk) disable iff (rst)
        (kind == K_REG) |-> (rt.off[4:3] == psw_q[4:3] && rt.off[15:5] == '0));
endmodule

// File: tb/dmem_map_tb.sv
module dmem_map_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic        req_we = 1'b0;
    logic [7:0]  req_wdata = 8'h0;
    logic [7:0]  rd_data;
    logic        rd_bit;
    logic        off_chip;
    logic [7:0]  sp_q;
    logic [15:0] dptr_q;
    logic [7:0]  psw_q;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] got;
    logic       got_off;
    bit         finished = 0;

    localparam logic [2:0] DIR = 3'd0, IND = 3'd1, BIT = 3'd2, RG = 3'd3,
                           MVX = 3'd4, PSH = 3'd5, POP = 3'd6;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmem_map u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_bit(rd_bit), .off_chip(off_chip),
        .sp_q(sp_q), .dptr_q(dptr_q), .psw_q(psw_q)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [2:0] k, input logic [15:0] a,
                      input logic w, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_we = w; req_wdata = d;
        #1;
        got = rd_data; got_off = off_chip;
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 sp reset", {8'h0, sp_q}, 16'h0007);
        chk("R11 dptr reset", dptr_q, 16'h0000);
        chk("R11 psw reset", {8'h0, psw_q}, 16'h0000);
        op(DIR, 16'h81, 0, 0);
        chk("R7 sp read at 81h", {8'h0, got}, 16'h0007);
    endtask

    task automatic t_split();
        op(DIR, 16'h40, 1, 8'h11);
        op(IND, 16'h40, 0, 0);
        chk("R1 direct low reaches RAM", {8'h0, got}, 16'h0011);
        op(DIR, 16'h90, 1, 8'hA5);
        op(IND, 16'h90, 1, 8'h3C);
        op(IND, 16'h90, 0, 0);
        chk("R2 indirect 90h holds RAM byte", {8'h0, got}, 16'h003C);
        op(DIR, 16'h90, 0, 0);
        chk("R1 direct 90h is unimplemented SFR", {8'h0, got}, 16'h0000);
    endtask

    task automatic t_banks();
        for (int b = 0; b < 4; b++) begin
            op(DIR, 16'hD0, 1, 8'(b << 3));
            for (int n = 0; n < 8; n++) op(RG, 16'(n), 1, 8'(8'h50 + b*8 + n));
        end
        for (int b = 0; b < 4; b++) begin
            for (int n = 0; n < 8; n++) begin
                op(IND, 16'(b*8 + n), 0, 0);
                chk("R3 bank mapping", {8'h0, got}, 16'(8'h50 + b*8 + n));
            end
        end
        op(DIR, 16'hD0, 1, 8'h10);
        op(RG, 16'h5, 0, 0);
        chk("R3 register read in bank 2", {8'h0, got}, 16'h0065);
        op(DIR, 16'hD0, 1, 8'h00);
    endtask

    task automatic t_bit_ram();
        op(IND, 16'h25, 1, 8'hF0);
        op(BIT, 16'h2B, 1, 8'h01);
        op(IND, 16'h25, 0, 0);
        chk("R4 bit set keeps neighbours", {8'h0, got}, 16'h00F8);
        op(BIT, 16'h2C, 1, 8'h00);
        op(IND, 16'h25, 0, 0);
        chk("R4 bit clear keeps neighbours", {8'h0, got}, 16'h00E8);
        op(BIT, 16'h2B, 0, 0);
        chk("R4 bit read one", {8'h0, got}, 16'h0001);
        op(BIT, 16'h2A, 0, 0);
        chk("R4 bit read zero", {8'h0, got}, 16'h0000);
        op(IND, 16'h2F, 1, 8'h00);
        op(BIT, 16'h7F, 1, 8'h01);
        op(IND, 16'h2F, 0, 0);
        chk("R4 top bit address", {8'h0, got}, 16'h0080);
    endtask

    task automatic t_bit_sfr_psw();
        op(DIR, 16'hE0, 1, 8'h00);
        op(BIT, 16'hE2, 1, 8'h01);
        op(DIR, 16'hE0, 0, 0);
        chk("R5 bit write to accumulator", {8'h0, got}, 16'h0004);
        chk("R6 parity after bit write", {15'h0, psw_q[0]}, 16'h0001);
        op(BIT, 16'hD0, 1, 8'h00);
        chk("R6 parity bit not writable", {15'h0, psw_q[0]}, 16'h0001);
        op(BIT, 16'hD0, 0, 0);
        chk("R5 bit read of status parity", {8'h0, got}, 16'h0001);
        op(DIR, 16'hE0, 1, 8'h03);
        op(DIR, 16'hD0, 1, 8'hFF);
        op(DIR, 16'hD0, 0, 0);
        chk("R6 status layout even acc", {8'h0, got}, 16'h00FE);
        op(DIR, 16'hE0, 1, 8'h07);
        chk("R6 status with odd acc", {8'h0, psw_q}, 16'h00FF);
        op(DIR, 16'hD0, 1, 8'h00);
        op(DIR, 16'hE0, 1, 8'h00);
    endtask

    task automatic t_stack();
        op(DIR, 16'h81, 1, 8'h07);
        op(PSH, 16'h0, 0, 8'hAA);
        chk("R7 push increments", {8'h0, sp_q}, 16'h0008);
        op(PSH, 16'h0, 0, 8'hBB);
        op(IND, 16'h08, 0, 0);
        chk("R7 push wrote new top", {8'h0, got}, 16'h00AA);
        op(POP, 16'h0, 0, 0);
        chk("R7 pop returns top", {8'h0, got}, 16'h00BB);
        chk("R7 pop decrements", {8'h0, sp_q}, 16'h0008);
        op(DIR, 16'h81, 1, 8'hFF);
        op(PSH, 16'h0, 0, 8'hCC);
        chk("R7 push wraps", {8'h0, sp_q}, 16'h0000);
        op(IND, 16'h00, 0, 0);
        chk("R7 wrapped push target", {8'h0, got}, 16'h00CC);
        op(POP, 16'h0, 0, 0);
        chk("R7 pop wraps", {8'h0, sp_q}, 16'h00FF);
        op(DIR, 16'h81, 1, 8'h8F);
        op(PSH, 16'h0, 0, 8'h77);
        op(IND, 16'h90, 0, 0);
        chk("R7 high stack in upper RAM", {8'h0, got}, 16'h0077);
        op(DIR, 16'h90, 0, 0);
        chk("R7 high stack not in SFR", {8'h0, got}, 16'h0000);
        op(DIR, 16'h81, 1, 8'h07);
    endtask

    task automatic t_dptr();
        op(DIR, 16'h82, 1, 8'h34);
        op(DIR, 16'h83, 1, 8'h12);
        chk("R8 data pointer halves", dptr_q, 16'h1234);
        op(DIR, 16'h83, 0, 0);
        chk("R8 high byte read", {8'h0, got}, 16'h0012);
    endtask

    task automatic t_xram();
        op(MVX, 16'h0010, 1, 8'h5A);
        chk("R10 disabled move off chip", {15'h0, got_off}, 16'h0001);
        op(DIR, 16'hBF, 1, 8'h01);
        op(DIR, 16'hBF, 0, 0);
        chk("R9 control readback", {8'h0, got}, 16'h0001);
        op(MVX, 16'h0010, 1, 8'h11);
        chk("R9 enabled move on chip", {15'h0, got_off}, 16'h0000);
        op(DIR, 16'hBF, 1, 8'h00);
        op(MVX, 16'h0010, 1, 8'h5A);
        op(MVX, 16'h0010, 0, 0);
        chk("R10 disabled read is zero", {8'h0, got}, 16'h0000);
        op(DIR, 16'hBF, 1, 8'h01);
        op(MVX, 16'h0010, 0, 0);
        chk("R10 disabled write left array", {8'h0, got}, 16'h0011);
        op(MVX, 16'h02FF, 1, 8'h9C);
        op(MVX, 16'h02FF, 0, 0);
        chk("R9 last on-chip byte", {8'h0, got}, 16'h009C);
        op(MVX, 16'h0000, 1, 8'h22);
        op(MVX, 16'h0300, 1, 8'h99);
        chk("R10 above range off chip", {15'h0, got_off}, 16'h0001);
        op(MVX, 16'h0000, 0, 0);
        chk("R10 no alias to low address", {8'h0, got}, 16'h0022);
        op(MVX, 16'h0300, 0, 0);
        chk("R10 above range reads zero", {8'h0, got}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_split();
        t_banks();
        t_bit_ram();
        t_bit_sfr_psw();
        t_stack();
        t_dptr();
        t_xram();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end
endmodule